// File: doc/BRIEF.md
# Serial Word EEPROM Model

This block is a synthesizable behavioural model of a small serial EEPROM that stores 16-bit words and talks over a select line, a serial clock, a data input and a data output. A host raises the select line, clocks in a start bit, a two-bit opcode and an address, followed by a data word where the command needs one. For reads, the model shifts the stored word back out. The model can read, write or erase one word, erase or write every word at once, and turn programming on or off.

All pins are sampled by a fast system clock. A rising edge of the serial clock is found by comparing each sample with the one taken before it. Storage is a register array with 2^ADDR_W words, where ADDR_W is 6 or 8. Every word comes out of reset erased, and programming comes out of reset disabled. A command takes effect as soon as its last bit has been captured. There is no modelled programming delay.

Top module: `serial_eeprom_model`

## Requirements
- R1: While idle with select high, data-in bits of 0 sampled at serial clock rises are skipped. The first 1 is taken as the start bit. It is followed by the opcode (MSB first), then ADDR_W address bits (MSB first), then 16 data bits (MSB first) for the commands that carry data.
- R2: Opcode 10 reads. At the rise that captures the last address bit, data-out goes to 0. Each of the next 16 rises presents one bit of the addressed word, starting with bit 15.
- R3: Opcode 01 writes the following 16 data bits to the addressed word.
- R4: Opcode 11 sets the addressed word to 16'hFFFF.
- R5: Programming starts disabled after reset. Opcode 00 with the top two address bits 11 enables it, and with 00 disables it. While programming is disabled, write, erase, erase-all and write-all leave the array unchanged.
- R6: Opcode 00 with the top two address bits 10 sets every word to 16'hFFFF. The remaining address bits are ignored.
- R7: Opcode 00 with the top two address bits 01 writes the following 16 data bits to every word.
- R8: A low select line abandons any partly received command, changes no word, and returns the model to waiting for a start bit.
- R9: Data-out is 1 while select is low, after reset, and whenever no read is shifting. This includes the rise that follows the last bit of a read.
- R10: After reset every word reads as 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; its rising edges shift bits in and out |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |

## Verification
Every address is read back after each of these changes: reset, a full-range write attempt with programming disabled, a full-range write of an address-dependent pattern, erasure of every third word, an erase-all and a write-all. This separates address decode errors, enable gating errors and bulk-versus-single errors. The pattern mixes the address into both data bytes, so a bit-order or off-by-one shift error shows up as a mismatch. The leading zero of each read is checked, as is the idle-high data-out after the last bit. Commands are cut short by dropping select part-way through a write and part-way through a read, and a command is preceded by spurious zero bits.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial EEPROM model: decoder states, opcodes and
// array operation codes. Assumes 2-bit opcodes and 2-bit subcommands.
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_DONE
    } eep_state_e;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    localparam logic [1:0] SUB_PROG_OFF = 2'b00;
    localparam logic [1:0] SUB_FILL_ALL = 2'b01;
    localparam logic [1:0] SUB_WIPE_ALL = 2'b10;
    localparam logic [1:0] SUB_PROG_ON  = 2'b11;

    typedef enum logic [1:0] {
        AOP_NONE,
        AOP_ONE,
        AOP_ALL
    } arr_op_e;
endpackage

// File: rtl/eep_sclk_edge.sv
`timescale 1ns/1ps
// Rising-edge detector for the serial clock.
// Assumes sclk is already synchronous to clk and is held for at least
// two clk cycles per level.
module eep_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    // Remember the previous serial clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/eep_word_array.sv
`timescale 1ns/1ps
// Word storage with single-word and all-word update, plus an async read port.
// Assumes at most one operation per cycle; reset leaves every word erased.
module eep_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  eep_pkg::arr_op_e       op,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic hit;
        assign hit = (op == eep_pkg::AOP_ALL) ||
                     ((op == eep_pkg::AOP_ONE) && (wr_addr == ADDR_W'(g)));
        // Update this word on a matching single or bulk operation.
        always_ff @(posedge clk) begin
            if (!rst_n)   words[g] <= '1;
            else if (hit) words[g] <= wr_data;
        end
    end

    assign rd_word = words[rd_addr];
endmodule

// File: rtl/eep_cmd_decoder.sv
`timescale 1ns/1ps
// Serial command decoder: start-bit hunt, opcode/address capture, data
// capture, read shift-out and the programming-enable latch.
// Assumes one serial-clock rise pulse per sampled rising edge.
module eep_cmd_decoder #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel,
    input  logic                   rise,
    input  logic                   sdi,
    input  logic [DATA_W-1:0]      rd_word,
    output logic [ADDR_W-1:0]      rd_addr,
    output eep_pkg::arr_op_e       arr_op,
    output logic [ADDR_W-1:0]      arr_addr,
    output logic [DATA_W-1:0]      arr_data,
    output eep_pkg::eep_state_e    state,
    output logic                   wen,
    output logic                   sdo
);
    import eep_pkg::*;

    localparam int CMD_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(DATA_W + CMD_W + 1);

    eep_state_e         st;
    logic [CNT_W-1:0]   cnt;
    logic [CMD_W-2:0]   cmd_sr;
    logic [DATA_W-2:0]  data_sr;
    logic [DATA_W-1:0]  rd_sr;
    logic [1:0]         op_q;
    logic [ADDR_W-1:0]  addr_q;

    logic [CMD_W-1:0]   cmd_now;
    logic [DATA_W-1:0]  data_now;
    logic [1:0]         op_now;
    logic [ADDR_W-1:0]  addr_now;
    logic [1:0]         sub_now;
    logic               cmd_last;
    logic               data_last;

    assign cmd_now   = {cmd_sr, sdi};
    assign data_now  = {data_sr, sdi};
    assign op_now    = cmd_now[CMD_W-1 -: 2];
    assign addr_now  = cmd_now[ADDR_W-1:0];
    assign sub_now   = addr_now[ADDR_W-1 -: 2];
    assign cmd_last  = (cnt == CNT_W'(CMD_W - 1));
    assign data_last = (cnt == CNT_W'(DATA_W - 1));
    assign rd_addr   = addr_now;

    // Derive this cycle's array operation from a completed command.
    always_comb begin
        arr_op   = AOP_NONE;
        arr_addr = addr_q;
        arr_data = data_now;
        if (sel && rise && wen) begin
            if (st == ST_CMD && cmd_last) begin
                arr_addr = addr_now;
                arr_data = '1;
                if (op_now == OPC_ERASE) arr_op = AOP_ONE;
                else if (op_now == OPC_SPECIAL && sub_now == SUB_WIPE_ALL) arr_op = AOP_ALL;
            end else if (st == ST_DATA && data_last) begin
                arr_op = (op_q == OPC_WRITE) ? AOP_ONE : AOP_ALL;
            end
        end
    end

    // Sequence the command phases and drive the serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            cmd_sr  <= '0;
            data_sr <= '0;
            rd_sr   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            wen     <= 1'b0;
            sdo     <= 1'b1;
        end else if (!sel) begin
            st  <= ST_IDLE;
            cnt <= '0;
            sdo <= 1'b1;
        end else if (rise) begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (sdi) st <= ST_CMD;
                end
                ST_CMD: begin
                    cmd_sr <= cmd_now[CMD_W-2:0];
                    cnt    <= cnt + CNT_W'(1);
                    if (cmd_last) begin
                        cnt    <= '0;
                        op_q   <= op_now;
                        addr_q <= addr_now;
                        st     <= ST_DONE;
                        case (op_now)
                            OPC_READ: begin
                                rd_sr <= rd_word;
                                sdo   <= 1'b0;
                                st    <= ST_READ;
                            end
                            OPC_WRITE: st <= ST_DATA;
                            OPC_SPECIAL: begin
                                if (sub_now == SUB_PROG_ON)  wen <= 1'b1;
                                if (sub_now == SUB_PROG_OFF) wen <= 1'b0;
                                if (sub_now == SUB_FILL_ALL) st  <= ST_DATA;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DATA: begin
                    data_sr <= data_now[DATA_W-2:0];
                    cnt     <= cnt + CNT_W'(1);
                    if (data_last) st <= ST_DONE;
                end
                ST_READ: begin
                    if (cnt == CNT_W'(DATA_W)) begin
                        sdo <= 1'b1;
                        st  <= ST_DONE;
                    end else begin
                        sdo   <= rd_sr[DATA_W-1];
                        rd_sr <= rd_sr << 1;
                        cnt   <= cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign state = st;
endmodule

// File: rtl/serial_eeprom_model.sv
`timescale 1ns/1ps
// Top of the serial EEPROM model: edge detector, command decoder and
// word array. Assumes ADDR_W is 6 or 8 and pins synchronous to clk.
module serial_eeprom_model #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);
    logic                  sclk_rise;
    logic [ADDR_W-1:0]     rd_addr;
    logic [DATA_W-1:0]     rd_word;
    eep_pkg::arr_op_e      arr_op;
    logic [ADDR_W-1:0]     arr_addr;
    logic [DATA_W-1:0]     arr_data;
    eep_pkg::eep_state_e   dec_state;
    logic                  wen;

    eep_sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (sclk_rise)
    );

    eep_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rise     (sclk_rise),
        .sdi      (sdi),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .arr_op   (arr_op),
        .arr_addr (arr_addr),
        .arr_data (arr_data),
        .state    (dec_state),
        .wen      (wen),
        .sdo      (sdo)
    );

    eep_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (arr_op),
        .wr_addr (arr_addr),
        .wr_data (arr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );
endmodule

// File: rtl/serial_eeprom_model_chk.sv
`timescale 1ns/1ps
// Protocol checker for the serial EEPROM model, bound into the top.
// Assumes the decoder state and enable latch are visible in the top scope.
module serial_eeprom_model_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                sel,
    input logic                sdi,
    input logic                sdo,
    input logic                rise,
    input eep_pkg::eep_state_e st,
    input logic                wen
);
    import eep_pkg::*;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rise && !sdi && st == ST_IDLE) |=> (st == ST_IDLE));

    // R2
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_READ) |-> !sdo);

    // R5
    wen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || !rise || st != ST_CMD) |=> $stable(wen));

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (st == ST_IDLE));

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> sdo);
endmodule

bind serial_eeprom_model serial_eeprom_model_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .sdi   (sdi),
    .sdo   (sdo),
    .rise  (sclk_rise),
    .st    (dec_state),
    .wen   (wen)
);

// File: tb/serial_eeprom_model_bench.sv
`timescale 1ns/1ps
// Self-checking bench: full-address sweeps against an arithmetic model.
module serial_eeprom_model_bench;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int vectors = 0;
    int misses  = 0;
    bit finished = 1'b0;

    logic [15:0] model [DEPTH];
    logic        model_wen = 1'b0;

    serial_eeprom_model #(.ADDR_W(AW), .DATA_W(16)) u_serial_eeprom_model (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi), .sdo(sdo)
    );

    always #2.5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One serial clock period; returns data-out sampled after the rise.
    task automatic clk_bit(input logic b, output logic v);
        sdi = b;
        tick(1);
        sclk = 1'b1;
        tick(2);
        v = sdo;
        sclk = 1'b0;
        tick(1);
    endtask

    task automatic send(input logic [31:0] val, input int n);
        logic v;
        for (int i = n - 1; i >= 0; i--) clk_bit(val[i], v);
    endtask

    task automatic deselect();
        sel = 1'b0;
        tick(3);
    endtask

    function automatic logic [15:0] pat(input int a);
        logic [15:0] p;
        p = 16'(a * 16'h9E37) ^ 16'h5A0F;
        return p;
    endfunction

    // Full command with optional data word; the model tracks effects.
    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] adr, input logic [15:0] d);
        logic [1:0] sub;
        sub = adr[AW-1 -: 2];
        sel = 1'b1;
        tick(2);
        send(32'(1), 1);
        send(32'(op), 2);
        send(32'(adr), AW);
        if (op == 2'b01 || (op == 2'b00 && sub == 2'b01)) send(32'(d), 16);
        deselect();
        if (op == 2'b00 && sub == 2'b11) model_wen = 1'b1;
        if (op == 2'b00 && sub == 2'b00) model_wen = 1'b0;
        if (model_wen) begin
            if (op == 2'b01) model[adr] = d;
            if (op == 2'b11) model[adr] = 16'hFFFF;
            if (op == 2'b00 && sub == 2'b10) for (int k = 0; k < DEPTH; k++) model[k] = 16'hFFFF;
            if (op == 2'b00 && sub == 2'b01) for (int k = 0; k < DEPTH; k++) model[k] = d;
        end
    endtask

    task automatic read_word(input logic [AW-1:0] adr, input string req);
        logic v;
        logic [15:0] w;
        sel = 1'b1;
        tick(2);
        send(32'(1), 1);
        send(32'(2'b10), 2);
        for (int i = AW - 1; i >= 0; i--) clk_bit(adr[i], v);
        check(v == 1'b0, "R2 leading zero", 16'(v), 16'h0);
        for (int i = 15; i >= 0; i--) begin
            clk_bit(1'b0, v);
            w[i] = v;
        end
        check(w == model[adr], req, w, model[adr]);
        clk_bit(1'b0, v);
        if (adr == 0) check(v == 1'b1, "R9 high after read", 16'(v), 16'h1);
        deselect();
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) read_word(AW'(a), req);
    endtask

    initial begin
        logic v;
        for (int k = 0; k < DEPTH; k++) model[k] = 16'hFFFF;
        tick(4);
        check(sdo == 1'b1, "R9 reset sdo", 16'(sdo), 16'h1);
        rst_n = 1'b1;
        tick(2);
        sel = 1'b1;
        tick(2);
        clk_bit(1'b0, v);
        check(v == 1'b1, "R9 idle selected", 16'(v), 16'h1);
        deselect();

        // R10: erased after reset
        sweep("R10 reset contents");

        // R5: writes ignored while programming disabled after reset
        for (int a = 0; a < DEPTH; a++) cmd(2'b01, AW'(a), pat(a));
        sweep("R5 disabled writes");

        // R1: zeros before the start bit, then enable
        sel = 1'b1;
        tick(2);
        send(32'(0), 3);
        send(32'(1), 1);
        send(32'(2'b00), 2);
        send(32'({2'b11, {(AW-2){1'b0}}}), AW);
        deselect();
        model_wen = 1'b1;

        // R3: write every word
        for (int a = 0; a < DEPTH; a++) cmd(2'b01, AW'(a), pat(a));
        sweep("R1 R3 word write");

        // R4: erase every third word
        for (int a = 0; a < DEPTH; a += 3) cmd(2'b11, AW'(a), 16'h0);
        sweep("R4 word erase");

        // R8: abort a write half way; sdo high while deselected
        sel = 1'b1;
        tick(2);
        send(32'(1), 1);
        send(32'(2'b01), 2);
        send(32'(5), AW);
        send(32'(16'h00), 8);
        sel = 1'b0;
        tick(2);
        check(sdo == 1'b1, "R9 deselected", 16'(sdo), 16'h1);
        tick(1);
        read_word(AW'(5), "R8 aborted write");
        // R8: abort a read half way, then a new read works
        sel = 1'b1;
        tick(2);
        send(32'(1), 1);
        send(32'(2'b10), 2);
        send(32'(7), AW);
        send(32'(0), 5);
        deselect();
        read_word(AW'(8), "R8 after aborted read");

        // R6: erase all (low address bits nonzero)
        cmd(2'b00, AW'({2'b10, {(AW-2){1'b1}}}), 16'h0);
        sweep("R6 erase all");

        // R7: write all
        cmd(2'b00, AW'({2'b01, {(AW-2){1'b0}}}), 16'h1234);
        sweep("R7 write all");

        // R5: disable, then every programming command is ignored
        cmd(2'b00, AW'(0), 16'h0);
        cmd(2'b01, AW'(7), 16'hBEEF);
        cmd(2'b11, AW'(8), 16'h0);
        cmd(2'b00, AW'({2'b10, {(AW-2){1'b0}}}), 16'h0);
        cmd(2'b00, AW'({2'b01, {(AW-2){1'b0}}}), 16'h0F0F);
        sweep("R5 disabled after off");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule